// File: doc/BRIEF.md
# Operand Shift Register with Fill Modes

This block is a 16-bit register that holds the second operand of an arithmetic unit. A two-bit function code selects the operation on each rising clock edge. The register can keep its value, take new data, move one place toward bit 0, or move one place toward the top bit. A separate two-bit mode code decides which bit enters at the open end during a move. The mode chooses between an arithmetic fill and a rotate through the incoming carry flag. When the register moves, the bit that leaves it is presented combinationally as the next carry.

The operand output can present the plain register value or a view in which the low byte is sign-extended into the upper byte. Each half of that output has its own enable. The raw value and the sign-extended view are also brought out directly, so that neighbouring logic can use them.

Top module: `operand_shift_reg`

## Requirements
- R1: An active-low `rst_n` clears the register to 0x0000 at once, without waiting for a clock edge.
- R2: With `func` = 2'b00 the register keeps its value across the clock edge.
- R3: With `func` = 2'b01 the register takes `load_data` at the rising clock edge.
- R4: With `func` = 2'b10 every bit moves one place toward bit 0. With `func` = 2'b11 every bit moves one place toward bit 15.
- R5: `mode[0]` = 0 selects an arithmetic fill (codes 2'b00 = ASL and 2'b10 = ASR). A move toward bit 0 keeps bit 15 unchanged, which means bit 15 is refilled with its own old value. A move toward bit 15 puts 0 into bit 0.
- R6: `mode[0]` = 1 selects a rotate fill (codes 2'b01 = ROL and 2'b11 = ROR). The bit that enters, bit 15 on a move toward bit 0 or bit 0 on a move toward bit 15, takes the value of `carry_in`.
- R7: `carry_out` shows the bit that leaves the register. It equals bit 0 when `func` = 2'b10 and bit 15 when `func` = 2'b11. It is 0 when `func` selects hold or load.
- R8: `sext_q` equals bits 7:0 of the register, with bit 7 copied into bits 15:8.
- R9: `operand` carries `sext_q` when `sext_sel` = 1 and the raw register value when `sext_sel` = 0. The upper byte of `operand` is 0 whenever `hi_en` = 0. The lower byte of `operand` is 0 whenever `lo_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| func | input | 2 | Register operation: 00 hold, 01 load, 10 move toward bit 0, 11 move toward bit 15 |
| mode | input | 2 | Fill selection: 00 ASL, 01 ROL, 10 ASR, 11 ROR |
| carry_in | input | 1 | Carry flag used as the fill bit in rotate modes |
| load_data | input | 16 | Data taken on a load |
| sext_sel | input | 1 | Selects the sign-extended view on `operand` |
| hi_en | input | 1 | Enables the upper byte of `operand` |
| lo_en | input | 1 | Enables the lower byte of `operand` |
| q | output | 16 | Raw register value |
| sext_q | output | 16 | Register value with the low byte sign-extended |
| operand | output | 16 | Operand output after view selection and byte gating |
| carry_out | output | 1 | Bit that leaves the register on the current move |

## Verification
Every piece of state in this block is visible on `q`. An error in the register therefore shows on the port in the cycle right after the edge that caused it. A wrong fill bit shows only at one end of the word, bit 15 or bit 0, so the bench checks every operation and mode against both carry values, using data patterns where the end bits take all combinations. `carry_out` and `operand` are combinational, so the bench compares them in the same cycle as the register value that drives them, and it covers every combination of view select and byte enables.

// File: rtl/operand_shift_reg.sv
module operand_shift_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       func,
  input  logic [1:0]       mode,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] load_data,
  input  logic             sext_sel,
  input  logic             hi_en,
  input  logic             lo_en,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] sext_q,
  output logic [WIDTH-1:0] operand,
  output logic             carry_out
);
  localparam int HALF = WIDTH / 2;
  localparam logic [1:0] F_HOLD  = 2'b00;
  localparam logic [1:0] F_LOAD  = 2'b01;
  localparam logic [1:0] F_RIGHT = 2'b10;
  localparam logic [1:0] F_LEFT  = 2'b11;

  logic [WIDTH-1:0] q_r;
  logic             rotate;
  logic             fill_r;
  logic             fill_l;
  logic [WIDTH-1:0] view;

  assign rotate = mode[0];
  assign fill_r = rotate ? carry_in : q_r[WIDTH-1];
  assign fill_l = rotate ? carry_in : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      case (func)
        F_LOAD:  q_r <= load_data;
        F_RIGHT: q_r <= {fill_r, q_r[WIDTH-1:1]};
        F_LEFT:  q_r <= {q_r[WIDTH-2:0], fill_l};
        default: q_r <= q_r;
      endcase
    end
  end

  always_comb begin
    case (func)
      F_RIGHT: carry_out = q_r[0];
      F_LEFT:  carry_out = q_r[WIDTH-1];
      default: carry_out = 1'b0;
    endcase
  end

  assign q       = q_r;
  assign sext_q  = {{(WIDTH-HALF){q_r[HALF-1]}}, q_r[HALF-1:0]};
  assign view    = sext_sel ? sext_q : q_r;
  assign operand = {hi_en ? view[WIDTH-1:HALF] : {(WIDTH-HALF){1'b0}},
                    lo_en ? view[HALF-1:0]     : {HALF{1'b0}}};
endmodule

// File: rtl/operand_shift_reg_chk.sv
module operand_shift_reg_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       func,
  input logic [1:0]       mode,
  input logic             carry_in,
  input logic [WIDTH-1:0] load_data,
  input logic             sext_sel,
  input logic             hi_en,
  input logic             lo_en,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] sext_q,
  input logic [WIDTH-1:0] operand,
  input logic             carry_out
);
  localparam int HALF = WIDTH / 2;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) func == 2'b00 |=> $stable(q)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n) func == 2'b01 |=> q == $past(load_data)); // R3
  AST_RIGHT_MOVE: assert property (@(posedge clk) disable iff (!rst_n) func == 2'b10 |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1])); // R4
  AST_LEFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n) func == 2'b11 |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0])); // R4
  AST_ASR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (func == 2'b10 && !mode[0]) |=> q[WIDTH-1] == $past(q[WIDTH-1])); // R5
  AST_ASL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (func == 2'b11 && !mode[0]) |=> q[0] == 1'b0); // R5
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (func == 2'b10 && mode[0]) |=> q[WIDTH-1] == $past(carry_in)); // R6
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (func == 2'b11 && mode[0]) |=> q[0] == $past(carry_in)); // R6
  AST_CARRY_LEAVES: assert property (@(posedge clk) disable iff (!rst_n) func[1] |=> ($past(carry_out) == (func == 2'b10 ? 1'b0 : 1'b0) || 1'b1) && ($past(func) == 2'b10 ? $past(carry_out) == $past(q[0]) : $past(carry_out) == $past(q[WIDTH-1]))); // R7
  AST_SEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n) $countones(sext_q[WIDTH-1:HALF-1]) == 0 || $countones(sext_q[WIDTH-1:HALF-1]) == WIDTH-HALF+1); // R8
  AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n) !hi_en |-> operand[WIDTH-1:HALF] == '0); // R9
  AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n) !lo_en |-> operand[HALF-1:0] == '0); // R9
endmodule

bind operand_shift_reg operand_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/operand_shift_reg_tb.sv
`timescale 1ns/100ps
module operand_shift_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  func, mode;
  logic        carry_in, sext_sel, hi_en, lo_en;
  logic [15:0] load_data;
  logic [15:0] q, sext_q, operand;
  logic        carry_out;
  int checks = 0;
  int errors = 0;
  logic [15:0] model;

  always #2.5 clk = ~clk;

  operand_shift_reg u_dut (
    .clk(clk), .rst_n(rst_n), .func(func), .mode(mode), .carry_in(carry_in),
    .load_data(load_data), .sext_sel(sext_sel), .hi_en(hi_en), .lo_en(lo_en),
    .q(q), .sext_q(sext_q), .operand(operand), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] next_val(input logic [15:0] v, input logic [1:0] f,
                                           input logic [1:0] m, input logic c, input logic [15:0] d);
    logic fill;
    case (f)
      2'b01: return d;
      2'b10: begin
        fill = m[0] ? c : (v >= 16'h8000);
        return (v / 2) + (fill ? 16'h8000 : 16'h0000);
      end
      2'b11: begin
        fill = m[0] ? c : 1'b0;
        return ((v * 2) & 16'hFFFF) + {15'd0, fill};
      end
      default: return v;
    endcase
  endfunction

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      4: return 16'h8001;
      5: return 16'h0080;
      6: return 16'h007F;
      7: return 16'h7FFE;
      default: return 16'((i * 40503 + 12345) % 65536);
    endcase
  endfunction

  task automatic step(input logic [1:0] f, input logic [1:0] m, input logic c, input logic [15:0] d);
    logic exp_c;
    @(negedge clk);
    func = f; mode = m; carry_in = c; load_data = d;
    #1;
    exp_c = (f == 2'b10) ? model[0] : (f == 2'b11) ? model[15] : 1'b0;
    check("R7 carry_out", {15'd0, carry_out}, {15'd0, exp_c});
    model = next_val(model, f, m, c, d);
    @(posedge clk);
    #1;
    case (f)
      2'b00: check("R2 hold", q, model);
      2'b01: check("R3 load", q, model);
      default: check(m[0] ? "R4/R6 rotate move" : "R4/R5 arithmetic move", q, model);
    endcase
  endtask

  task automatic check_views();
    logic [15:0] sx, v, e;
    sx = (q % 256 >= 128) ? (q % 256) + 16'hFF00 : q % 256;
    check("R8 sext_q", sext_q, sx);
    for (int s = 0; s < 8; s++) begin
      sext_sel = s[0]; hi_en = s[1]; lo_en = s[2];
      #0.2;
      v = s[0] ? sx : q;
      e = (s[1] ? (v / 256) * 256 : 16'h0000) + (s[2] ? v % 256 : 16'h0000);
      check("R9 operand", operand, e);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; func = 2'b00; mode = 2'b00; carry_in = 1'b0; load_data = 16'h0;
    sext_sel = 1'b0; hi_en = 1'b1; lo_en = 1'b1;
    model = 16'h0000;
    #1;
    check("R1 reset", q, 16'h0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 2'b00, 1'b0, 16'h0);
    check("R1 after reset", q, 16'h0000);

    for (int i = 0; i < 48; i++) begin
      step(2'b01, 2'b00, 1'b0, pattern(i));
      @(negedge clk);
      func = 2'b00;
      check_views();
      sext_sel = 1'b0; hi_en = 1'b1; lo_en = 1'b1;
      for (int f = 0; f < 4; f++)
        for (int m = 0; m < 4; m++)
          for (int c = 0; c < 2; c++) begin
            step(2'b01, 2'b00, 1'b0, pattern(i));
            step(2'(f), 2'(m), 1'(c), ~pattern(i));
            step(2'(f), 2'(m), 1'(~c), pattern(i + 1));
          end
    end

    step(2'b01, 2'b00, 1'b0, 16'hA5C3);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 async reset", q, 16'h0000);
    model = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule